// File: doc/BRIEF.md
# Register-Controlled Multiply-Accumulate Unit

This block is a memory-mapped arithmetic helper for a processor. Software loads two 16-bit operands and a mode word. The unit multiplies the operands, either signed or unsigned, and places the result in a 40-bit accumulator. The product can stand alone, be added to the accumulator, or be taken away from it. A square mode takes one operand value as both factors. The operation starts on its own when the operands are written. The trigger is either "both operands written" or "any operand written".

The accumulator is read and written as three words. Two are full 16-bit words. The third holds the top 8 bits in its low byte. The mode register carries a sticky overflow indication. A self-clearing clear command zeroes the data state. A hold bit lets software compute a result and its overflow status without touching the accumulator.

Top module: `regmac_unit`

## Requirements
- R1: After reset every register reads 0. The address map is: 0 mode, 1 operand A, 2 operand B, 3 accumulator bits 15:0, 4 accumulator bits 31:16, 5 accumulator bits 39:32 in bits 7:0 with bits 15:8 reading 0. Addresses 6 and 7 read 0.
- R2: Mode bits are: 7 overflow (read-only), 6 hold, 5 clear (always reads 0), 4 square, 3 single-trigger, 2 negate, 1 accumulate, 0 unsigned. Bits 6, 4, 3, 2, 1 and 0 read back what was written.
- R3: With single-trigger = 0 and square = 0, an operation starts only once both A and B have been written since the last start. After each start this tracking returns to "none written".
- R4: With single-trigger = 1, a write to either operand starts an operation using the stored value of the other operand.
- R5: With square = 1, a write to A or B stores the value in both operands and starts an operation at once, whatever the single-trigger bit says.
- R6: The accumulator shows the result on the clock edge after the triggering write. With unsigned = 0 the operands are two's complement and the 32-bit product is sign-extended to 40 bits. With unsigned = 1 the operands are magnitudes and the product is zero-extended.
- R7: With accumulate = 1 the product is added to the accumulator, or subtracted from it when negate = 1. The accumulator is read as signed or unsigned to match the unsigned bit.
- R8: With accumulate = 0 and negate = 1, a signed operation stores the negated product. An unsigned operation stores the plain product and sets overflow.
- R9: Each completed operation replaces the overflow bit. It is 1 when the 40-bit accumulate/subtract result goes out of range (signed range for signed mode, 0 to 2^40-1 for unsigned mode), or in the R8 unsigned-negate case. Otherwise it is 0.
- R10: Writing the mode register with bit 5 = 1 zeroes A, B, the accumulator and overflow, forgets written operands, and cancels a pending operation. Writing bit 5 = 0 clears nothing.
- R11: With hold = 1 an operation updates overflow but leaves the accumulator unchanged.
- R12: If an operation completes in the same cycle as a bus write to an accumulator word, the result wins. With hold = 1 the bus write is applied. A clear command in the same cycle as a completion wins over the completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |

## Verification
Two collisions need care. A completing operation can meet a bus write to an accumulator word, and it can meet a clear command in the same cycle. The bench provokes both. It writes the second operand and then, on the very next cycle, writes an accumulator word or issues a clear while the operation is still pending. It repeats this with hold set and with hold clear. The behavioural model applies the priority stated in R12. Every clock, the read data is compared against the model, so the word that won the collision shows up on the following reads of that word.

// File: rtl/regmac_pkg.sv
`timescale 1ns/1ps
package regmac_pkg;
    localparam int OP_W   = 16;
    localparam int ACC_W  = 40;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_OPA    = 3'd1;
    localparam logic [ADDR_W-1:0] REG_OPB    = 3'd2;
    localparam logic [ADDR_W-1:0] REG_ACC_LO = 3'd3;
    localparam logic [ADDR_W-1:0] REG_ACC_MD = 3'd4;
    localparam logic [ADDR_W-1:0] REG_ACC_HI = 3'd5;

    localparam int BIT_OVF  = 7;
    localparam int BIT_HOLD = 6;
    localparam int BIT_CLR  = 5;
    localparam int BIT_SQR  = 4;
    localparam int BIT_ONE  = 3;
    localparam int BIT_NEG  = 2;
    localparam int BIT_ACC  = 1;
    localparam int BIT_UNS  = 0;

    typedef struct packed {
        logic hold;
        logic square;
        logic single;
        logic negate;
        logic accum;
        logic unsgn;
    } mode_t;
endpackage

// File: rtl/regmac_regs.sv
`timescale 1ns/1ps
module regmac_regs
    import regmac_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output mode_t             mode_o,
    output logic [W-1:0]      op_a_o,
    output logic [W-1:0]      op_b_o,
    output logic              fire_o,
    output logic              clear_o
);
    typedef struct packed {
        mode_t        mode;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         seen_a;
        logic         seen_b;
        logic         fire;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    clear_c;
    logic    hit_a;

    always_comb begin
        st_d    = st_q;
        st_d.fire = 1'b0;
        clear_c = wr_en && (wr_addr == REG_MODE) && wr_data[BIT_CLR];
        hit_a   = (wr_addr == REG_OPA);
        if (wr_en) begin
            if (wr_addr == REG_MODE) begin
                st_d.mode.hold   = wr_data[BIT_HOLD];
                st_d.mode.square = wr_data[BIT_SQR];
                st_d.mode.single = wr_data[BIT_ONE];
                st_d.mode.negate = wr_data[BIT_NEG];
                st_d.mode.accum  = wr_data[BIT_ACC];
                st_d.mode.unsgn  = wr_data[BIT_UNS];
            end else if (wr_addr == REG_OPA || wr_addr == REG_OPB) begin
                if (st_q.mode.square) begin
                    st_d.a    = wr_data;
                    st_d.b    = wr_data;
                    st_d.fire = 1'b1;
                end else begin
                    if (hit_a) st_d.a = wr_data;
                    else       st_d.b = wr_data;
                    if (st_q.mode.single || (hit_a ? st_q.seen_b : st_q.seen_a))
                        st_d.fire = 1'b1;
                    else if (hit_a)
                        st_d.seen_a = 1'b1;
                    else
                        st_d.seen_b = 1'b1;
                end
                if (st_d.fire) begin
                    st_d.seen_a = 1'b0;
                    st_d.seen_b = 1'b0;
                end
            end
        end
        if (clear_c) begin
            st_d.a      = '0;
            st_d.b      = '0;
            st_d.seen_a = 1'b0;
            st_d.seen_b = 1'b0;
            st_d.fire   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o  = st_q.mode;
    assign op_a_o  = st_q.a;
    assign op_b_o  = st_q.b;
    assign fire_o  = st_q.fire;
    assign clear_o = clear_c;

    AST_START_FORGETS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> !(st_q.seen_a || st_q.seen_b)); // R3
    AST_SQUARE_SAME_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fire && st_q.mode.square) |-> (st_q.a == st_q.b)); // R5
    AST_CLEAR_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        clear_c |=> (!st_q.fire && st_q.a == '0 && st_q.b == '0)); // R10
endmodule

// File: rtl/regmac_arith.sv
`timescale 1ns/1ps
module regmac_arith
    import regmac_pkg::*;
#(
    parameter int W  = OP_W,
    parameter int AW = ACC_W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [AW-1:0] acc,
    input  mode_t         mode,
    output logic [AW-1:0] result,
    output logic          ovf
);
    localparam int PW  = 2 * W;
    localparam int EXT = AW + 1 - PW;

    logic [PW-1:0] a_x, b_x, prod;
    logic [AW:0]   prod_ext, acc_ext, sum;

    always_comb begin
        a_x  = mode.unsgn ? {{W{1'b0}}, a} : {{W{a[W-1]}}, a};
        b_x  = mode.unsgn ? {{W{1'b0}}, b} : {{W{b[W-1]}}, b};
        prod = a_x * b_x;
        prod_ext = mode.unsgn ? {{EXT{1'b0}}, prod} : {{EXT{prod[PW-1]}}, prod};
        acc_ext  = mode.unsgn ? {1'b0, acc} : {acc[AW-1], acc};
        if (mode.accum) begin
            sum = mode.negate ? (acc_ext - prod_ext) : (acc_ext + prod_ext);
            ovf = mode.unsgn ? sum[AW] : (sum[AW] != sum[AW-1]);
        end else begin
            sum = (mode.negate && !mode.unsgn) ? ({(AW+1){1'b0}} - prod_ext) : prod_ext;
            ovf = mode.negate && mode.unsgn;
        end
        result = sum[AW-1:0];
    end
endmodule

// File: rtl/regmac_unit.sv
`timescale 1ns/1ps
module regmac_unit
    import regmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [OP_W-1:0]   bus_wdata,
    output logic [OP_W-1:0]   bus_rdata
);
    localparam int HI_W = ACC_W - 2 * OP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } astate_t;

    astate_t          st_d, st_q;
    mode_t            mode;
    logic [OP_W-1:0]  op_a, op_b;
    logic             fire, clear;
    logic [ACC_W-1:0] res_c;
    logic             ovf_c;
    logic             acc_wr;

    regmac_regs #(.W(OP_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mode_o  (mode),
        .op_a_o  (op_a),
        .op_b_o  (op_b),
        .fire_o  (fire),
        .clear_o (clear)
    );

    regmac_arith #(.W(OP_W), .AW(ACC_W)) u_arith (
        .a      (op_a),
        .b      (op_b),
        .acc    (st_q.acc),
        .mode   (mode),
        .result (res_c),
        .ovf    (ovf_c)
    );

    always_comb begin
        st_d   = st_q;
        acc_wr = bus_we && (bus_addr == REG_ACC_LO || bus_addr == REG_ACC_MD ||
                            bus_addr == REG_ACC_HI);
        if (clear) begin
            st_d = '0;
        end else begin
            if (fire) begin
                st_d.ovf = ovf_c;
                if (!mode.hold) st_d.acc = res_c;
            end
            if (acc_wr && !(fire && !mode.hold)) begin
                if (bus_addr == REG_ACC_LO)      st_d.acc[OP_W-1:0]      = bus_wdata;
                else if (bus_addr == REG_ACC_MD) st_d.acc[2*OP_W-1:OP_W] = bus_wdata;
                else                             st_d.acc[ACC_W-1:2*OP_W] = bus_wdata[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_MODE: begin
                bus_rdata[BIT_OVF]  = st_q.ovf;
                bus_rdata[BIT_HOLD] = mode.hold;
                bus_rdata[BIT_SQR]  = mode.square;
                bus_rdata[BIT_ONE]  = mode.single;
                bus_rdata[BIT_NEG]  = mode.negate;
                bus_rdata[BIT_ACC]  = mode.accum;
                bus_rdata[BIT_UNS]  = mode.unsgn;
            end
            REG_OPA:    bus_rdata = op_a;
            REG_OPB:    bus_rdata = op_b;
            REG_ACC_LO: bus_rdata = st_q.acc[OP_W-1:0];
            REG_ACC_MD: bus_rdata = st_q.acc[2*OP_W-1:OP_W];
            REG_ACC_HI: bus_rdata[HI_W-1:0] = st_q.acc[ACC_W-1:2*OP_W];
            default:    bus_rdata = '0;
        endcase
    end

    AST_HOLD_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode.hold && !acc_wr && !clear) |=> $stable(st_q.acc)); // R11
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.acc == '0 && !st_q.ovf)); // R10
    AST_UNS_NEGATE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode.unsgn && mode.negate && !mode.accum && !clear) |=> st_q.ovf); // R8
    AST_RESULT_BEATS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mode.hold && acc_wr && !clear) |=> (st_q.acc == $past(res_c))); // R12
endmodule

// File: tb/regmac_unit_test.sv
`timescale 1ns/1ps
module regmac_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    logic [6:0]  m_mode = '0;   // bit 5 always 0
    bit          m_of = 0;
    logic [15:0] m_a = '0, m_b = '0;
    logic [39:0] m_acc = '0;
    bit          m_la = 0, m_lb = 0, m_go = 0;

    localparam longint L40 = 64'h100_0000_0000;
    localparam longint L39 = 64'h080_0000_0000;

    always #2.5 clk = ~clk;

    regmac_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {8'd0, m_of, m_mode};
            3'd1: return m_a;
            3'd2: return m_b;
            3'd3: return m_acc[15:0];
            3'd4: return m_acc[31:16];
            3'd5: return {8'd0, m_acc[39:32]};
            default: return 16'd0;
        endcase
    endfunction

    task automatic m_compute(output logic [39:0] res, output bit ov);
        longint pa, pb, p, av, s;
        bit uns, mac, sub;
        uns = m_mode[0]; mac = m_mode[1]; sub = m_mode[2];
        pa = uns ? longint'(m_a) : longint'($signed(m_a));
        pb = uns ? longint'(m_b) : longint'($signed(m_b));
        p  = pa * pb;
        if (mac) begin
            av = longint'(m_acc);
            if (!uns && m_acc[39]) av = av - L40;
            s  = sub ? av - p : av + p;
            ov = uns ? (s < 0 || s >= L40) : (s < -L39 || s >= L39);
        end else begin
            s  = (sub && !uns) ? -p : p;
            ov = sub && uns;
        end
        res = s[39:0];
    endtask

    task automatic m_step(input bit we, input logic [2:0] a, input logic [15:0] d);
        logic [39:0] r;
        bit ov, took, fire;
        logic [39:0] n_acc;
        took = 0; fire = 0; n_acc = m_acc;
        if (m_go) begin
            m_compute(r, ov);
            m_of = ov;
            if (!m_mode[6]) begin n_acc = r; took = 1; end
        end
        if (we) begin
            if (a == 3'd0) begin
                if (d[5]) begin
                    m_a = 0; m_b = 0; n_acc = 0; m_of = 0; m_la = 0; m_lb = 0;
                end
                m_mode = {d[6], 1'b0, d[4:0]};
            end else if (a == 3'd1 || a == 3'd2) begin
                if (m_mode[4]) begin
                    m_a = d; m_b = d; fire = 1;
                end else begin
                    if (a == 3'd1) m_a = d; else m_b = d;
                    if (m_mode[3]) fire = 1;
                    else if (a == 3'd1) begin if (m_lb) fire = 1; else m_la = 1; end
                    else begin if (m_la) fire = 1; else m_lb = 1; end
                end
                if (fire) begin m_la = 0; m_lb = 0; end
            end else if (!took) begin
                if (a == 3'd3) n_acc[15:0] = d;
                else if (a == 3'd4) n_acc[31:16] = d;
                else if (a == 3'd5) n_acc[39:32] = d[7:0];
            end
        end
        m_acc = n_acc;
        m_go  = fire;
    endtask

    // one bus cycle: drive, compare current read data with the model, advance
    task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d, input string tag);
        logic [15:0] exp;
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        exp = m_read(a);
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: addr=%0d rd_data=%h expected %h", tag, a, bus_rdata, exp);
        end
        @(posedge clk);
        m_step(we, a, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        step(1, a, d, tag);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(0, a, 16'd0, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 8; i++) rd(3'(i), tag);
    endtask

    task automatic set_acc(input logic [39:0] v, input string tag);
        wr(3'd3, v[15:0], tag);
        wr(3'd4, v[31:16], tag);
        wr(3'd5, {8'd0, v[39:32]}, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, no requirement finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and address map
        rd_all("R1");
        // R2 mode register bits
        wr(3'd0, 16'hFFFF, "R2"); rd(3'd0, "R2");
        wr(3'd0, 16'h0000, "R2"); rd(3'd0, "R2");
        // R3 two-write trigger, R6 signed timing
        wr(3'd1, 16'd3, "R3"); rd(3'd3, "R3");
        wr(3'd1, 16'd5, "R3"); rd(3'd3, "R3");
        wr(3'd2, 16'd7, "R3"); rd_all("R6");
        wr(3'd2, 16'd2, "R3"); rd(3'd3, "R3");
        wr(3'd1, 16'hFFFC, "R6"); rd_all("R6");
        // R4 single-operand trigger
        wr(3'd0, 16'h0008, "R4");
        wr(3'd1, 16'd10, "R4"); rd_all("R4");
        wr(3'd2, 16'h8000, "R4"); rd_all("R4");
        // R6 unsigned magnitude
        wr(3'd0, 16'h0009, "R6");
        wr(3'd1, 16'hFFFF, "R6"); wr(3'd2, 16'hFFFF, "R6"); rd_all("R6");
        // R5 square overrides trigger count
        wr(3'd0, 16'h0010, "R5");
        wr(3'd1, 16'hFFFE, "R5"); rd_all("R5");
        wr(3'd2, 16'h8000, "R5"); rd_all("R5");
        wr(3'd0, 16'h0012, "R5");
        wr(3'd1, 16'd3, "R5"); rd_all("R5");
        // R7 accumulate and subtract
        wr(3'd0, 16'h0000, "R7"); wr(3'd0, 16'h0020, "R7");
        wr(3'd0, 16'h0002, "R7");
        wr(3'd1, 16'd100, "R7"); wr(3'd2, 16'd200, "R7"); rd_all("R7");
        wr(3'd1, 16'hFFF6, "R7"); wr(3'd2, 16'd1000, "R7"); rd_all("R7");
        wr(3'd0, 16'h0006, "R7");
        wr(3'd1, 16'd7, "R7"); wr(3'd2, 16'd9, "R7"); rd_all("R7");
        wr(3'd0, 16'h0007, "R7");
        set_acc(40'h00_0001_0000, "R7");
        wr(3'd1, 16'd2, "R7"); wr(3'd2, 16'd3, "R7"); rd_all("R7");
        // R8 negate without accumulate
        wr(3'd0, 16'h0004, "R8");
        wr(3'd1, 16'd3, "R8"); wr(3'd2, 16'd5, "R8"); rd_all("R8");
        wr(3'd0, 16'h0005, "R8");
        wr(3'd1, 16'd4, "R8"); wr(3'd2, 16'd6, "R8"); rd_all("R8");
        // R9 overflow in each mode, then cleared by a clean operation
        wr(3'd0, 16'h0002, "R9");
        set_acc(40'h7F_FFFF_FFFF, "R9");
        wr(3'd1, 16'd1, "R9"); wr(3'd2, 16'd1, "R9"); rd_all("R9");
        wr(3'd1, 16'd1, "R9"); wr(3'd2, 16'd1, "R9"); rd_all("R9");
        wr(3'd0, 16'h0003, "R9");
        set_acc(40'hFF_FFFF_FFFF, "R9");
        wr(3'd1, 16'd1, "R9"); wr(3'd2, 16'd1, "R9"); rd_all("R9");
        wr(3'd0, 16'h0007, "R9");
        wr(3'd1, 16'd1, "R9"); wr(3'd2, 16'd1, "R9"); rd_all("R9");
        // R11 hold keeps accumulator, flag still updates
        wr(3'd0, 16'h0047, "R11");
        set_acc(40'h00_0000_0005, "R11");
        wr(3'd1, 16'd2, "R11"); wr(3'd2, 16'd3, "R11"); rd_all("R11");
        wr(3'd0, 16'h0040, "R11");
        wr(3'd1, 16'd9, "R11"); wr(3'd2, 16'd9, "R11"); rd_all("R11");
        // R10 clear command, and writing bit 5 = 0 clears nothing
        wr(3'd0, 16'h0005, "R10");
        wr(3'd1, 16'd1, "R10"); wr(3'd2, 16'd1, "R10"); rd(3'd0, "R10");
        wr(3'd0, 16'h0000, "R10"); rd_all("R10");
        wr(3'd1, 16'd4, "R10");
        wr(3'd0, 16'h0020, "R10"); rd_all("R10");
        wr(3'd2, 16'd6, "R10"); rd_all("R10");
        wr(3'd1, 16'd2, "R10"); rd_all("R10");
        // R12 collisions between completion, bus writes and clear
        wr(3'd0, 16'h0000, "R12");
        wr(3'd1, 16'd11, "R12"); wr(3'd2, 16'd13, "R12");
        wr(3'd3, 16'h1234, "R12"); rd_all("R12");
        wr(3'd1, 16'd2, "R12"); wr(3'd2, 16'd2, "R12");
        wr(3'd5, 16'h00AB, "R12"); rd_all("R12");
        wr(3'd0, 16'h0040, "R12");
        wr(3'd1, 16'd5, "R12"); wr(3'd2, 16'd5, "R12");
        wr(3'd4, 16'h5A5A, "R12"); rd_all("R12");
        wr(3'd0, 16'h0000, "R12");
        wr(3'd1, 16'd7, "R12"); wr(3'd2, 16'd7, "R12");
        wr(3'd0, 16'h0020, "R12"); rd_all("R12");
        wr(3'd0, 16'h0008, "R12");
        wr(3'd1, 16'd3, "R12"); wr(3'd2, 16'd4, "R12"); rd_all("R12");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule